// File: doc/BRIEF.md
# Dual-Bus Transfer Control Decoder

This block turns one microcode step into the per-unit control strobes of a CPU with a 16-bit data bus and a 16-bit address bus. Each clock cycle the step names one source and one sink on each bus: a 4-bit source and sink code for the data bus and a 3-bit source and sink code for the address bus. The block registers the four codes on the rising clock edge. It then drives one-hot, active-low output enables for the two sources and write strobes for the two sinks. The data bus has sixteen unit slots and the address bus has eight, and the two transfers happen in the same cycle.

The write strobes follow the clock. A strobe stays high while the clock is high in the first half of the bus cycle. For the selected sink only, it falls while the clock is low in the second half. The sink therefore captures on the rising edge that ends the cycle. Output enables move from one source to the next at that same edge, with no idle cycle between them. Each strobe also comes as an active-high load-enable that lasts the whole cycle, for register models that run on the single clock. The built-in RAM (data slot 1) uses whatever address is on the address bus. A step that only touches RAM therefore names address slot 7 as a dummy sink.

A small state machine has two states. ST_HOLD is entered by reset, and all outputs are idle in it. ST_XFER drives the decoded strobes. The transition "release" goes from ST_HOLD to ST_XFER on the first rising edge after reset is removed. The transition "step" goes from ST_XFER to ST_XFER on every later edge. Reset (asynchronous, active low) returns the machine to ST_HOLD from either state.

Top module: `bus_xfer_decoder`

## Requirements
- R1: In ST_XFER, `dbus_oe_n` has exactly one bit low, the bit whose index equals `dbus_src` as sampled at the most recent rising edge; all other bits are high.
- R2: In ST_XFER, `abus_oe_n` has exactly one bit low, at the index `abus_src` held at the most recent rising edge; all other bits are high.
- R3: In ST_XFER, every bit of `dbus_wr_n` is high while `clk` is high. While `clk` is low, only bit `dbus_dst` (as registered at the most recent rising edge) is low.
- R4: In ST_XFER, every bit of `abus_wr_n` is high while `clk` is high. While `clk` is low, only bit `abus_dst` (as registered) is low.
- R5: `dbus_ld` and `abus_ld` are active-high one-hot load-enables at the registered sink index. They stay high for the whole cycle, and each bit is high exactly when the matching write strobe pulses low in that cycle.
- R6: Every code decodes to its own slot, including unused data slots 9 and 11, top slot 15 and address dummy slot 7. A source and a sink on the same slot index are both driven in the same cycle.
- R7: Changing any select input between rising edges has no effect on the output enables or load-enables until the next rising edge.
- R8: While `rst_n` is low, and after its release until the first rising edge, all enables and write strobes are high and all load-enables are low.
- R9: From one step to the next, the old source enable rises and the new one falls at the same edge. At every sample point within ST_XFER, exactly one enable per bus is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; high half then low half of each bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbus_src | input | 4 | Data-bus source slot code |
| dbus_dst | input | 4 | Data-bus sink slot code |
| abus_src | input | 3 | Address-bus source slot code |
| abus_dst | input | 3 | Address-bus sink slot code |
| dbus_oe_n | output | 16 | Active-low output enables, data-bus units |
| dbus_wr_n | output | 16 | Clock-shaped active-low write strobes, data-bus units |
| dbus_ld | output | 16 | Active-high one-cycle load-enables, data-bus units |
| abus_oe_n | output | 8 | Active-low output enables, address-bus units |
| abus_wr_n | output | 8 | Clock-shaped active-low write strobes, address-bus units |
| abus_ld | output | 8 | Active-high one-cycle load-enables, address-bus units |

## Verification
The source enable and the sink strobe of one bus can land on the same slot in the same cycle, for example a unit reloading from its own output. That case is provoked with vectors whose source and sink codes are equal (ALU, D3, stack pointer, dummy slot). It is judged by checking, in both clock phases of that cycle, that the enable stays low throughout while the strobe on the same index is high in the first half and low in the second. A second overlap is a new step being presented while the previous step's strobe is still low. The bench changes the selects in the low phase and checks that the enables from before the change stay put.

// File: rtl/bxd_pkg.sv
`timescale 1ns/1ps
package bxd_pkg;

    // Controller phase: idle after reset, then one transfer per cycle
    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_XFER = 1'b1
    } xfer_state_e;

endpackage

// File: rtl/bxd_onehot_dec.sv
`timescale 1ns/1ps
module bxd_onehot_dec #(
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0]        sel,
    input  logic                    en,
    output logic [(1<<SEL_W)-1:0]   hot
);

    localparam int SLOTS = 1 << SEL_W;

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
        assign hot[gi] = en && (sel == SEL_W'(gi));
    end

endmodule

// File: rtl/bxd_strobe_shaper.sv
`timescale 1ns/1ps
module bxd_strobe_shaper #(
    parameter int SLOTS = 16
) (
    input  logic             clk,
    input  logic [SLOTS-1:0] sink_hot,
    output logic [SLOTS-1:0] wr_n
);

    // High in the first (clock-high) half, low in the second half for
    // the chosen sink; the rising clock edge ends the pulse.
    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_pulse
        assign wr_n[gi] = ~(sink_hot[gi] & ~clk);
    end

endmodule

// File: rtl/bxd_ctrl_fsm.sv
`timescale 1ns/1ps
module bxd_ctrl_fsm
    import bxd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic active
);

    xfer_state_e state_q;
    xfer_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = ST_XFER;   // release
            ST_XFER: state_d = ST_XFER;   // step
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_HOLD: active = 1'b0;
            ST_XFER: active = 1'b1;
        endcase
    end

endmodule

// File: rtl/bxd_bus_lane.sv
`timescale 1ns/1ps
module bxd_bus_lane #(
    parameter int SEL_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     active,
    input  logic [SEL_W-1:0]         src,
    input  logic [SEL_W-1:0]         dst,
    output logic [(1<<SEL_W)-1:0]    oe_n,
    output logic [(1<<SEL_W)-1:0]    wr_n,
    output logic [(1<<SEL_W)-1:0]    ld
);

    localparam int SLOTS = 1 << SEL_W;

    logic [SEL_W-1:0] src_q;
    logic [SEL_W-1:0] dst_q;
    logic [SLOTS-1:0] src_hot;
    logic [SLOTS-1:0] dst_hot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else begin
            src_q <= src;
            dst_q <= dst;
        end
    end

    bxd_onehot_dec #(.SEL_W(SEL_W)) src_dec_i (
        .sel (src_q),
        .en  (active),
        .hot (src_hot)
    );

    bxd_onehot_dec #(.SEL_W(SEL_W)) dst_dec_i (
        .sel (dst_q),
        .en  (active),
        .hot (dst_hot)
    );

    bxd_strobe_shaper #(.SLOTS(SLOTS)) shaper_i (
        .clk      (clk),
        .sink_hot (dst_hot),
        .wr_n     (wr_n)
    );

    assign oe_n = ~src_hot;
    assign ld   = dst_hot;

endmodule

// File: rtl/bus_xfer_decoder.sv
`timescale 1ns/1ps
module bus_xfer_decoder #(
    parameter int D_SEL_W = 4,
    parameter int A_SEL_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [D_SEL_W-1:0]         dbus_src,
    input  logic [D_SEL_W-1:0]         dbus_dst,
    input  logic [A_SEL_W-1:0]         abus_src,
    input  logic [A_SEL_W-1:0]         abus_dst,
    output logic [(1<<D_SEL_W)-1:0]    dbus_oe_n,
    output logic [(1<<D_SEL_W)-1:0]    dbus_wr_n,
    output logic [(1<<D_SEL_W)-1:0]    dbus_ld,
    output logic [(1<<A_SEL_W)-1:0]    abus_oe_n,
    output logic [(1<<A_SEL_W)-1:0]    abus_wr_n,
    output logic [(1<<A_SEL_W)-1:0]    abus_ld
);

    logic active;

    bxd_ctrl_fsm fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active)
    );

    bxd_bus_lane #(.SEL_W(D_SEL_W)) dlane_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .src    (dbus_src),
        .dst    (dbus_dst),
        .oe_n   (dbus_oe_n),
        .wr_n   (dbus_wr_n),
        .ld     (dbus_ld)
    );

    bxd_bus_lane #(.SEL_W(A_SEL_W)) alane_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .src    (abus_src),
        .dst    (abus_dst),
        .oe_n   (abus_oe_n),
        .wr_n   (abus_wr_n),
        .ld     (abus_ld)
    );

endmodule

// File: rtl/bxd_chk.sv
`timescale 1ns/1ps
module bxd_chk #(
    parameter int D_SEL_W = 4,
    parameter int A_SEL_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [D_SEL_W-1:0]         dbus_src,
    input  logic [D_SEL_W-1:0]         dbus_dst,
    input  logic [A_SEL_W-1:0]         abus_src,
    input  logic [A_SEL_W-1:0]         abus_dst,
    input  logic [(1<<D_SEL_W)-1:0]    dbus_oe_n,
    input  logic [(1<<D_SEL_W)-1:0]    dbus_wr_n,
    input  logic [(1<<D_SEL_W)-1:0]    dbus_ld,
    input  logic [(1<<A_SEL_W)-1:0]    abus_oe_n,
    input  logic [(1<<A_SEL_W)-1:0]    abus_wr_n,
    input  logic [(1<<A_SEL_W)-1:0]    abus_ld
);

    localparam int DS = 1 << D_SEL_W;
    localparam int AS = 1 << A_SEL_W;

    logic               live;
    logic [D_SEL_W-1:0] cap_dsrc;
    logic [D_SEL_W-1:0] cap_ddst;
    logic [A_SEL_W-1:0] cap_asrc;
    logic [A_SEL_W-1:0] cap_adst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live     <= 1'b0;
            cap_dsrc <= '0;
            cap_ddst <= '0;
            cap_asrc <= '0;
            cap_adst <= '0;
        end else begin
            live     <= 1'b1;
            cap_dsrc <= dbus_src;
            cap_ddst <= dbus_dst;
            cap_asrc <= abus_src;
            cap_adst <= abus_dst;
        end
    end

    AST_DOE_FOLLOWS_SEL: assert property (@(negedge clk) disable iff (!rst_n)
        live |-> (~dbus_oe_n == (DS'(1) << cap_dsrc))); // R1

    AST_AOE_FOLLOWS_SEL: assert property (@(negedge clk) disable iff (!rst_n)
        live |-> (~abus_oe_n == (AS'(1) << cap_asrc))); // R2

    AST_DWR_HIGH_HALF: assert property (@(negedge clk) disable iff (!rst_n)
        live |-> (&dbus_wr_n)); // R3

    AST_DWR_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (~dbus_wr_n == (DS'(1) << cap_ddst))); // R3

    AST_AWR_HIGH_HALF: assert property (@(negedge clk) disable iff (!rst_n)
        live |-> (&abus_wr_n)); // R4

    AST_AWR_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (~abus_wr_n == (AS'(1) << cap_adst))); // R4

    AST_LD_MATCHES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> ((dbus_ld == ~dbus_wr_n) && (abus_ld == ~abus_wr_n))); // R5

    AST_ONE_SOURCE_EACH: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> ($countones(~dbus_oe_n) == 1 && $countones(~abus_oe_n) == 1)); // R9

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert ((&dbus_oe_n) && (&abus_oe_n) && (&dbus_wr_n)
                && (&abus_wr_n) && (dbus_ld == '0) && (abus_ld == '0)); // R8
        end
    end

endmodule

bind bus_xfer_decoder bxd_chk #(.D_SEL_W(D_SEL_W), .A_SEL_W(A_SEL_W)) chk_i (.*);

// File: tb/bus_xfer_decoder_tb_top.sv
`timescale 1ns/1ps
module bus_xfer_decoder_tb_top;

    logic        clk;
    logic        rst_n;
    logic [3:0]  dbus_src;
    logic [3:0]  dbus_dst;
    logic [2:0]  abus_src;
    logic [2:0]  abus_dst;
    logic [15:0] dbus_oe_n;
    logic [15:0] dbus_wr_n;
    logic [15:0] dbus_ld;
    logic [7:0]  abus_oe_n;
    logic [7:0]  abus_wr_n;
    logic [7:0]  abus_ld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Packed step: [13:10] data source, [9:6] data sink, [5:3] addr source, [2:0] addr sink
    localparam int NV = 13;
    localparam logic [13:0] VEC [NV] = '{
        {4'd0,  4'd4,  3'd0, 3'd7},
        {4'd1,  4'd5,  3'd3, 3'd7},
        {4'd5,  4'd1,  3'd4, 3'd7},
        {4'd8,  4'd8,  3'd2, 3'd2},
        {4'd15, 4'd14, 3'd1, 3'd3},
        {4'd9,  4'd11, 3'd6, 3'd0},
        {4'd11, 4'd9,  3'd5, 3'd6},
        {4'd3,  4'd2,  3'd7, 3'd1},
        {4'd12, 4'd13, 3'd3, 3'd4},
        {4'd10, 4'd15, 3'd2, 3'd5},
        {4'd14, 4'd0,  3'd0, 3'd0},
        {4'd2,  4'd12, 3'd1, 3'd7},
        {4'd7,  4'd7,  3'd7, 3'd7}
    };

    bus_xfer_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbus_src  (dbus_src),
        .dbus_dst  (dbus_dst),
        .abus_src  (abus_src),
        .abus_dst  (abus_dst),
        .dbus_oe_n (dbus_oe_n),
        .dbus_wr_n (dbus_wr_n),
        .dbus_ld   (dbus_ld),
        .abus_oe_n (abus_oe_n),
        .abus_wr_n (abus_wr_n),
        .abus_ld   (abus_ld)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [13:0] v);
        dbus_src = v[13:10];
        dbus_dst = v[9:6];
        abus_src = v[5:3];
        abus_dst = v[2:0];
    endtask

    task automatic chk_idle(input string req);
        chk(dbus_oe_n == 16'hFFFF, req, dbus_oe_n, 16'hFFFF);
        chk(abus_oe_n == 8'hFF, req, {8'h0, abus_oe_n}, 16'h00FF);
        chk(dbus_wr_n == 16'hFFFF, req, dbus_wr_n, 16'hFFFF);
        chk(abus_wr_n == 8'hFF, req, {8'h0, abus_wr_n}, 16'h00FF);
        chk(dbus_ld == 16'h0, req, dbus_ld, 16'h0);
        chk(abus_ld == 8'h0, req, {8'h0, abus_ld}, 16'h0);
    endtask

    // Clock-high half after the capturing edge: enables and load-enables set, strobes high
    task automatic chk_high(input logic [13:0] v);
        logic [15:0] eds = 16'h1 << v[13:10];
        logic [15:0] edd = 16'h1 << v[9:6];
        logic [7:0]  eas = 8'h1 << v[5:3];
        logic [7:0]  ead = 8'h1 << v[2:0];
        chk(dbus_oe_n == ~eds, "R1/R6/R9 dbus_oe_n", dbus_oe_n, ~eds);
        chk(abus_oe_n == ~eas, "R2/R6/R9 abus_oe_n", {8'h0, abus_oe_n}, {8'h0, ~eas});
        chk(dbus_wr_n == 16'hFFFF, "R3 dbus_wr_n high half", dbus_wr_n, 16'hFFFF);
        chk(abus_wr_n == 8'hFF, "R4 abus_wr_n high half", {8'h0, abus_wr_n}, 16'h00FF);
        chk(dbus_ld == edd, "R5 dbus_ld", dbus_ld, edd);
        chk(abus_ld == ead, "R5 abus_ld", {8'h0, abus_ld}, {8'h0, ead});
    endtask

    // Clock-low half: selected sink strobe low, enables unchanged
    task automatic chk_low(input logic [13:0] v);
        logic [15:0] eds = 16'h1 << v[13:10];
        logic [15:0] edd = 16'h1 << v[9:6];
        logic [7:0]  eas = 8'h1 << v[5:3];
        logic [7:0]  ead = 8'h1 << v[2:0];
        chk(dbus_wr_n == ~edd, "R3/R6 dbus_wr_n low half", dbus_wr_n, ~edd);
        chk(abus_wr_n == ~ead, "R4/R6 abus_wr_n low half", {8'h0, abus_wr_n}, {8'h0, ~ead});
        chk(dbus_oe_n == ~eds, "R7 dbus_oe_n held", dbus_oe_n, ~eds);
        chk(abus_oe_n == ~eas, "R7 abus_oe_n held", {8'h0, abus_oe_n}, {8'h0, ~eas});
        chk(dbus_ld == edd, "R5/R7 dbus_ld held", dbus_ld, edd);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL R-all watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(VEC[0]);
        // R8: idle while reset held, both clock phases
        @(posedge clk); #1 chk_idle("R8 reset high half");
        @(negedge clk); #1 chk_idle("R8 reset low half");
        rst_n = 1'b1;
        #1 chk_idle("R8 released before first edge");

        for (int i = 0; i < NV; i++) begin
            if (i > 0) begin
                @(negedge clk); #1;
                chk_low(VEC[i-1]);
                drive(VEC[i]);
                #1 chk_low(VEC[i-1]);   // R7: new selects mid-cycle change nothing
            end
            @(posedge clk); #1;
            chk_high(VEC[i]);
        end
        @(negedge clk); #1 chk_low(VEC[NV-1]);

        // R8: reset asserted mid-cycle, asynchronously
        drive(VEC[4]);
        rst_n = 1'b0;
        #1 chk_idle("R8 async assert");
        @(posedge clk); #1 chk_idle("R8 held across edge");
        @(negedge clk); #1;
        rst_n = 1'b1;
        #1 chk_idle("R8 after release low half");
        @(posedge clk); #1 chk_high(VEC[4]);
        @(negedge clk); #1 chk_low(VEC[4]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule